// File: doc/BRIEF.md
# Parallel flash command sequencer

This block is a clock-synchronous model of the command interface of a byte-wide parallel NOR flash. It samples active-low chip-enable, write-enable and output-enable strobes, an active-low reset pin, an 18-bit address and an 8-bit data bus on every clock edge. It recognises the multi-write unlock sequences that start a byte program, a sector erase, a chip erase or the boot-block lockout. A cycle counter stands in for the internal program and erase times, and the part returns to read mode when that counter runs out.

The address space is split into five sectors of unequal size: a 16 KB boot block, two 8 KB parameter blocks, a 96 KB main block and a 128 KB main block. With `TOP_BOOT` clear, the boot block sits at the bottom of the space. With it set, the whole map is mirrored so that the boot block sits at the top. The storage is a small behavioural window: each sector keeps 2^`OFS_W` bytes, and every address inside a sector folds onto the cell chosen by its low `OFS_W` bits. This keeps the sector boundaries and the erase scopes exact without building 256 KB of state.

Top module: `pflash_cmd_seq`

## Requirements
- R1: A bus write is an interval with `ce_n` and `we_n` low and `oe_n` high. Its address is sampled at the first clock edge of the interval and its data at the last clock edge of the interval. Strobes with `oe_n` low are not writes and leave the sequence where it was.
- R2: `dout_en` is high exactly when `reset_n` is high, `ce_n` is low, `oe_n` is low and `we_n` is high. While not busy, `dout` is the stored byte at `addr`.
- R3: Storage is indexed by sector number and `addr[OFS_W-1:0]`, so two addresses in one sector that share those low bits read the same byte. At power-up every byte reads FFh.
- R4: The byte program sequence is AAh@05555h, then 55h@02AAAh, then A0h@05555h, then data@target. When it completes, the target byte becomes old AND new.
- R5: The sector erase sequence is AAh@05555h, 55h@02AAAh, 80h@05555h, AAh@05555h, 55h@02AAAh, then 30h at any address. It sets every byte of the sector containing that sixth address to FFh and leaves all other sectors unchanged.
- R6: A chip erase uses the same five-write prefix as R5, then 10h@05555h. It sets every byte to FFh, except that the boot sector is kept while lockout is enabled.
- R7: Lockout is enabled by the same five-write prefix as R5, then 40h@05555h. After that, any program or sector erase that targets the boot sector changes nothing and starts no busy period. Lockout survives `reset_n` pulses.
- R8: A write whose address or data does not match the expected step returns the sequencer to idle, with no change to storage.
- R9: `busy` stays high for exactly `PROG_CYC` clock edges after a program write and `ERASE_CYC` edges after an erase command. All writes made while `busy` is high are ignored.
- R10: While `busy` is high and reads are enabled, `dout[7]` is the complement of bit 7 of the pending data (FFh for erases) and `dout[6:0]` is zero.
- R11: While `reset_n` is low, `dout_en` is low and any running operation is abandoned with no change to storage. After release, the part is in read mode.
- R12: With `TOP_BOOT` set, the map is mirrored: boot 3C000h–3FFFFh, parameter blocks 3A000h–3BFFFh and 38000h–39FFFh, main blocks 20000h–37FFFh and 00000h–1FFFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| reset_n | input | 1 | Active-low reset pin; aborts operations, floats outputs |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data bus |
| dout | output | 8 | Read data or data-polling status |
| dout_en | output | 1 | High when `dout` is driven onto the bus |
| busy | output | 1 | High while a program or erase is timing out |

## Verification
The assertions assume that `reset_n` is low at the first clock edge. They also assume that every write holds `ce_n` and `we_n` low across at least one sampling edge, with address and data steady at those edges. The bench drives each write for two edges from the falling clock edge. It parks read strobes between edges so that they never form a sampled write. It issues no second command until `busy` has fallen, except where R9 requires a deliberate overlap.

// File: rtl/pflash_cmd_seq.sv
module pflash_cmd_seq #(
  parameter int ADDR_W    = 18,
  parameter int OFS_W     = 6,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 40,
  parameter bit TOP_BOOT  = 1'b0
) (
  input  logic              clk,
  input  logic              reset_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en,
  output logic              busy
);
  localparam int NSEC  = 5;
  localparam int DEPTH = NSEC << OFS_W;
  localparam int IDX_W = OFS_W + 3;
  localparam int MAXC  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W = $clog2(MAXC);
  localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'('h5555);
  localparam logic [ADDR_W-1:0] KEY_B = ADDR_W'('h2AAA);

  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PROG, S_E0, S_E1, S_E2} st_t;
  typedef enum logic [1:0] {OP_PROG, OP_SEC, OP_CHIP} op_t;

  function automatic logic [2:0] sec_of(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] b;
    b = TOP_BOOT ? ~a : a;
    if (b[ADDR_W-1:14] == '0)                      return 3'd0;
    else if (b[ADDR_W-1:13] == (ADDR_W-13)'(2))    return 3'd1;
    else if (b[ADDR_W-1:13] == (ADDR_W-13)'(3))    return 3'd2;
    else if (!b[ADDR_W-1])                         return 3'd3;
    else                                           return 3'd4;
  endfunction

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return {sec_of(a), a[OFS_W-1:0]};
  endfunction

  logic [7:0]        mem [DEPTH];
  logic              locked = 1'b0;
  logic              act, act_q;
  logic [ADDR_W-1:0] a_q;
  logic [7:0]        d_q;
  st_t               st;
  op_t               op;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  pidx;
  logic [2:0]        psec;
  logic [7:0]        pdat;

  initial for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;

  assign act = !ce_n && !we_n && oe_n;

  wire ev       = act_q && !act && !busy;
  wire key1     = (a_q == KEY_A) && (d_q == 8'hAA);
  wire key2     = (a_q == KEY_B) && (d_q == 8'h55);
  wire boot_hit = locked && (sec_of(a_q) == 3'd0);
  wire commit   = busy && (cnt == '0);
  wire lock_set = ev && (st == S_E2) && (a_q == KEY_A) && (d_q == 8'h40);

  always_ff @(posedge clk) begin
    if (!reset_n) begin
      act_q <= 1'b0;
    end else begin
      act_q <= act;
      if (act && !act_q) a_q <= addr;
      if (act) d_q <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!reset_n) begin
      st   <= S_IDLE;
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (ev) begin
      st <= S_IDLE;
      case (st)
        S_IDLE: if (key1) st <= S_U1;
        S_U1:   if (key2) st <= S_U2;
        S_U2: begin
          if (a_q == KEY_A && d_q == 8'hA0)      st <= S_PROG;
          else if (a_q == KEY_A && d_q == 8'h80) st <= S_E0;
        end
        S_PROG: if (!boot_hit) begin
          op   <= OP_PROG;
          pidx <= idx_of(a_q);
          pdat <= d_q;
          busy <= 1'b1;
          cnt  <= CNT_W'(PROG_CYC - 1);
        end
        S_E0: if (key1) st <= S_E1;
        S_E1: if (key2) st <= S_E2;
        S_E2: begin
          if (a_q == KEY_A && d_q == 8'h10) begin
            op   <= OP_CHIP;
            pdat <= 8'hFF;
            busy <= 1'b1;
            cnt  <= CNT_W'(ERASE_CYC - 1);
          end else if (d_q == 8'h30 && !boot_hit) begin
            op   <= OP_SEC;
            psec <= sec_of(a_q);
            pdat <= 8'hFF;
            busy <= 1'b1;
            cnt  <= CNT_W'(ERASE_CYC - 1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (reset_n && lock_set) locked <= 1'b1;
    if (reset_n && commit) begin
      case (op)
        OP_PROG: mem[pidx] <= mem[pidx] & pdat;
        OP_SEC:  for (int i = 0; i < (1 << OFS_W); i++) mem[{psec, OFS_W'(i)}] <= 8'hFF;
        default: for (int i = 0; i < DEPTH; i++)
                   if (!locked || i >= (1 << OFS_W)) mem[IDX_W'(i)] <= 8'hFF;
      endcase
    end
  end

  assign dout_en = reset_n && !ce_n && !oe_n && we_n;
  assign dout    = busy ? {~pdat[7], 7'd0} : mem[idx_of(addr)];

endmodule

// File: rtl/pflash_cmd_seq_chk.sv
module pflash_cmd_seq_chk #(
  parameter int CNT_W     = 6,
  parameter int ERASE_CYC = 40
) (
  input logic             clk,
  input logic             reset_n,
  input logic             busy,
  input logic [CNT_W-1:0] cnt,
  input logic [2:0]       st,
  input logic [1:0]       op,
  input logic             locked,
  input logic             dout_en,
  input logic [7:0]       dout
);
  assert_busy_ends_R9: assert property (@(posedge clk) disable iff (!reset_n)
    busy && cnt == '0 |=> !busy);

  assert_busy_idle_R9: assert property (@(posedge clk) disable iff (!reset_n)
    busy |-> st == 3'd0);

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!reset_n)
    busy |-> int'(cnt) < ERASE_CYC);

  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!reset_n)
    !$fell(locked));

  assert_abort_R11: assert property (@(posedge clk) disable iff (!reset_n)
    $rose(reset_n) |-> !busy && st == 3'd0);

  assert_poll_erase_R10: assert property (@(posedge clk) disable iff (!reset_n)
    busy && op != 2'd0 && dout_en |-> dout == 8'h00);
endmodule

bind pflash_cmd_seq pflash_cmd_seq_chk #(.CNT_W(CNT_W), .ERASE_CYC(ERASE_CYC)) u_chk (
  .clk(clk), .reset_n(reset_n), .busy(busy), .cnt(cnt), .st(st), .op(op),
  .locked(locked), .dout_en(dout_en), .dout(dout)
);

// File: tb/tb_pflash_cmd_seq.sv
module tb_pflash_cmd_seq;
  localparam int OFS_W = 6, NC = 1 << OFS_W, NCELL = 5 * NC;
  localparam int PROG_CYC = 8, ERASE_CYC = 40;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic reset_n = 1'b0, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [17:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout_b, dout_t;
  logic        en_b, en_t, busy_b, busy_t;

  pflash_cmd_seq #(.OFS_W(OFS_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .TOP_BOOT(1'b0)) dut (
    .clk(clk), .reset_n(reset_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout_b), .dout_en(en_b), .busy(busy_b));
  pflash_cmd_seq #(.OFS_W(OFS_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .TOP_BOOT(1'b1)) dut_top (
    .clk(clk), .reset_n(reset_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout_t), .dout_en(en_t), .busy(busy_t));

  int n_chk = 0, n_fail = 0, blen = 0;
  bit bprev = 0, lk_b = 0, lk_t = 0;
  logic [7:0] mb [NCELL], mt [NCELL];

  always @(negedge clk) begin
    if (busy_b && !bprev) blen = 1;
    else if (busy_b) blen++;
    bprev = busy_b;
  end

  initial begin
    #4000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  function automatic int sec_of(logic [17:0] a, bit top);
    int b;
    b = top ? ('h3FFFF - int'(a)) : int'(a);
    if (b < 'h4000) return 0;
    if (b < 'h6000) return 1;
    if (b < 'h8000) return 2;
    if (b < 'h20000) return 3;
    return 4;
  endfunction

  function automatic int base_of(int s, bit top);
    int bb [5] = '{'h00000, 'h04000, 'h06000, 'h08000, 'h20000};
    int bt [5] = '{'h3C000, 'h3A000, 'h38000, 'h20000, 'h00000};
    return top ? bt[s] : bb[s];
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic m_prog(logic [17:0] a, logic [7:0] d);
    if (!(lk_b && sec_of(a, 0) == 0)) mb[sec_of(a, 0) * NC + int'(a % NC)] &= d;
    if (!(lk_t && sec_of(a, 1) == 0)) mt[sec_of(a, 1) * NC + int'(a % NC)] &= d;
  endtask

  task automatic m_sec(logic [17:0] a);
    int sb = sec_of(a, 0), st = sec_of(a, 1);
    for (int o = 0; o < NC; o++) begin
      if (!(lk_b && sb == 0)) mb[sb * NC + o] = 8'hFF;
      if (!(lk_t && st == 0)) mt[st * NC + o] = 8'hFF;
    end
  endtask

  task automatic m_chip();
    for (int i = 0; i < NCELL; i++) begin
      if (!lk_b || i >= NC) mb[i] = 8'hFF;
      if (!lk_t || i >= NC) mt[i] = 8'hFF;
    end
  endtask

  task automatic wr(logic [17:0] a, logic [7:0] d);
    @(negedge clk); addr = a; din = d; oe_n = 1; ce_n = 0; we_n = 0;
    @(negedge clk); @(negedge clk);
    we_n = 1; ce_n = 1;
    @(negedge clk);
  endtask

  task automatic rd(logic [17:0] a, output logic [7:0] vb, output logic [7:0] vt);
    addr = a; we_n = 1; ce_n = 0; oe_n = 0;
    #2; vb = dout_b; vt = dout_t;
    ce_n = 1; oe_n = 1;
    @(negedge clk);
  endtask

  task automatic unlock();
    wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h55);
  endtask

  task automatic cmd_prog(logic [17:0] a, logic [7:0] d);
    unlock(); wr(18'h05555, 8'hA0); wr(a, d);
  endtask

  task automatic cmd_e(logic [17:0] a, logic [7:0] d);
    unlock(); wr(18'h05555, 8'h80); unlock(); wr(a, d);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && (busy_b || busy_t); i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic sweep(string tag);
    int nbad = 0, fa = 0, fe = 0;
    logic [7:0] vb, vt, v, e;
    for (int top = 0; top < 2; top++)
      for (int s = 0; s < 5; s++)
        for (int o = 0; o < NC; o++) begin
          rd(18'(base_of(s, top[0]) + o), vb, vt);
          v = top ? vt : vb;
          e = top ? mt[s * NC + o] : mb[s * NC + o];
          if (v !== e) begin
            if (nbad == 0) begin fa = int'(v); fe = int'(e); end
            nbad++;
          end
        end
    chk(nbad == 0, tag, fa, fe);
  endtask

  initial begin
    logic [7:0] vb, vt, vb2, vt2;
    for (int i = 0; i < NCELL; i++) begin mb[i] = 8'hFF; mt[i] = 8'hFF; end

    repeat (3) @(negedge clk);
    ce_n = 0; oe_n = 0; #2;
    chk(!en_b && !en_t, "R11 outputs float in reset", int'(en_b), 0);
    ce_n = 1; oe_n = 1;
    @(negedge clk); reset_n = 1; @(negedge clk);
    chk(!busy_b && !busy_t, "R11 idle after reset", int'(busy_b), 0);

    for (int c = 0; c < 8; c++) begin
      ce_n = c[0]; we_n = c[1]; oe_n = c[2]; #2;
      chk(en_b == (c == 2) && en_t == (c == 2), "R2 output enable decode", int'(en_b), int'(c == 2));
      @(negedge clk);
    end
    ce_n = 1; we_n = 1; oe_n = 1; repeat (2) @(negedge clk);

    sweep("R3 erased at power-up");

    for (int k = 0; k < 10; k++) begin
      logic [17:0] a = 18'((k * 'h0D2A7 + 5) % 'h40000);
      logic [7:0]  d = 8'hF0 ^ 8'(k * 37);
      cmd_prog(a, d);
      rd(a, vb, vt);
      chk(vb == {~d[7], 7'd0} && vt == {~d[7], 7'd0}, "R10 program polling", int'(vb), int'({~d[7], 7'd0}));
      wait_idle();
      chk(blen == PROG_CYC, "R9 program busy length", blen, PROG_CYC);
      m_prog(a, d);
      cmd_prog(a, 8'h3C ^ 8'(k));
      wait_idle();
      m_prog(a, 8'h3C ^ 8'(k));
    end
    sweep("R4 program AND sweep");

    rd(18'h08005, vb, vt); rd(18'h080C5, vb2, vt2);
    chk(vb == vb2 && vb == mb[3 * NC + 5], "R3 sector fold", int'(vb2), int'(vb));

    wr(18'h05555, 8'hAA); wr(18'h02AAA, 8'h54); wr(18'h05555, 8'hA0); wr(18'h04007, 8'h00);
    unlock(); wr(18'h05556, 8'hA0); wr(18'h04007, 8'h00);
    unlock(); wr(18'h05555, 8'h80); wr(18'h05555, 8'hAA); wr(18'h02AAB, 8'h55); wr(18'h08000, 8'h30);
    repeat (4) @(negedge clk);
    chk(!busy_b && !busy_t, "R8 no busy after bad sequence", int'(busy_b), 0);
    sweep("R8 bad sequences leave storage");

    unlock();
    @(negedge clk); addr = 18'h05555; din = 8'hA0; ce_n = 0; we_n = 0; oe_n = 0;
    @(negedge clk); @(negedge clk); ce_n = 1; we_n = 1; oe_n = 1; @(negedge clk);
    wr(18'h05555, 8'hA0);
    @(negedge clk); addr = 18'h06013; din = 8'hFF; oe_n = 1; ce_n = 0; we_n = 0;
    @(negedge clk); addr = 18'h06014; din = 8'h81;
    @(negedge clk); we_n = 1; ce_n = 1; @(negedge clk);
    wait_idle();
    m_prog(18'h06013, 8'h81);
    sweep("R1 strobe capture rules");

    cmd_e(18'h08000, 8'h30);
    rd(18'h08000, vb, vt);
    chk(vb == 8'h00 && vt == 8'h00, "R10 erase polling", int'(vb), 0);
    cmd_prog(18'h20003, 8'h00);
    wait_idle();
    chk(blen == ERASE_CYC, "R9 erase busy length", blen, ERASE_CYC);
    m_sec(18'h08000);
    sweep("R9 writes ignored while busy");

    cmd_e(18'h04009, 8'h30);
    wait_idle();
    m_sec(18'h04009);
    sweep("R5 sector erase scope");

    cmd_prog(18'h06011, 8'h00);
    @(negedge clk); reset_n = 0;
    @(negedge clk); ce_n = 0; oe_n = 0; #2;
    chk(!en_b && !en_t, "R11 outputs float on abort", int'(en_b), 0);
    chk(!busy_b && !busy_t, "R11 busy cleared on abort", int'(busy_b), 0);
    ce_n = 1; oe_n = 1;
    @(negedge clk); reset_n = 1; repeat (PROG_CYC + 2) @(negedge clk);
    sweep("R11 aborted program has no effect");

    for (int k = 0; k < 6; k++) begin
      cmd_prog(18'(k * 'h7777 + 3), 8'h00); wait_idle(); m_prog(18'(k * 'h7777 + 3), 8'h00);
    end
    cmd_e(18'h05555, 8'h10); wait_idle(); m_chip();
    sweep("R6 chip erase unlocked");

    cmd_prog(18'h00021, 8'h5A); wait_idle(); m_prog(18'h00021, 8'h5A);
    cmd_prog(18'h3C021, 8'hA5); wait_idle(); m_prog(18'h3C021, 8'hA5);
    cmd_prog(18'h10022, 8'h0F); wait_idle(); m_prog(18'h10022, 8'h0F);
    cmd_e(18'h05555, 8'h40); lk_b = 1; lk_t = 1;
    cmd_prog(18'h00021, 8'h00); wait_idle(); m_prog(18'h00021, 8'h00);
    cmd_prog(18'h3C021, 8'h00); wait_idle(); m_prog(18'h3C021, 8'h00);
    rd(18'h3C021, vb, vt);
    chk(vt == 8'hA5 && vb == 8'h00, "R12 mirrored boot block", int'(vt), 'hA5);
    cmd_e(18'h00005, 8'h30); wait_idle(); m_sec(18'h00005);
    sweep("R7 boot block locked");

    @(negedge clk); reset_n = 0; repeat (2) @(negedge clk); reset_n = 1; @(negedge clk);
    cmd_prog(18'h00021, 8'h00); wait_idle(); m_prog(18'h00021, 8'h00);
    cmd_e(18'h3C001, 8'h30); wait_idle(); m_sec(18'h3C001);
    sweep("R7 lock persists over reset");

    cmd_e(18'h05555, 8'h10); wait_idle(); m_chip();
    sweep("R6 chip erase keeps locked boot");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule